// File: doc/BRIEF.md
# Fractional Event-Count Scheduler

This block runs once per 8 kHz isochronous cycle and decides how many audio events (sample frames) the packet for that cycle should carry. The configured sample rate is split into a whole number of events per cycle plus a remainder held over a fixed denominator of 8000. A ready accumulator keeps that remainder exactly, so no drift builds up over time. At 44.1 kHz, for example, the count moves between 5 and 6 and totals exactly 441 events over every 80 cycles.

Two transmission modes are supported. In the free-running mode a packet carries every whole event that has built up. In the blocking mode a packet carries either a full timestamp interval of events or none. A packet goes out only when the sample store holds enough samples and a packet slot is free. When either is missing, the cycle is skipped and the accumulator is left as it was. For each packet the block reports the event count, the packet byte length and the number of samples the store must release. Sample storage and packet formatting belong to the surrounding logic.

Top module: `evsched_top`

## Requirements
- R1: After synchronous reset, `ev_valid`, `ev_count`, `ev_bytes` and `pop_samples` are all zero.
- R2: A `cfg_load` pulse latches the rate, mode, interval and channel count, and clears the ready accumulator to zero. The rate is kept as `rate/8000` whole events plus `rate%8000` over 8000.
- R3: With `cfg_blocking`=0, each emitted count equals floor(ready + rate/8000). At 44100 Hz every count is 5 or 6, and 80 consecutive emitted packets carry exactly 441 events.
- R4: With `cfg_blocking`=1, the count is `cfg_syt` when floor(ready + rate/8000) ≥ `cfg_syt`, and 0 otherwise. A zero-event packet is still emitted.
- R5: A packet is emitted only when `slot_free`=1 and `avail_samples` ≥ count × channels. Otherwise there is no `ev_valid` and the accumulator is unchanged.
- R6: After an emitted packet, the whole part of the accumulator drops by the count and the fractional remainder is kept.
- R7: `pop_samples` = count × channels and `ev_bytes` = (count × channels + 2) × 4.
- R8: `ev_valid` is a one-cycle pulse in the cycle after a `cycle_tick`. There is no pulse without a tick.
- R9: In free-running mode the count never exceeds ceil(rate/8000). In blocking mode it never exceeds `cfg_syt`.
- R10: When `cfg_load` and `cycle_tick` are high in the same cycle, the configuration wins and no packet is emitted for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch configuration and clear accumulator |
| cfg_rate | input | RATE_W | Sample rate in Hz |
| cfg_blocking | input | 1 | 1 = blocking mode, 0 = free-running mode |
| cfg_syt | input | SYT_W | Events per timestamp interval |
| cfg_chans | input | CH_W | Channels per event |
| cycle_tick | input | 1 | One pulse per isochronous cycle |
| avail_samples | input | AV_W | Samples currently buffered |
| slot_free | input | 1 | A packet slot can accept a packet |
| ev_valid | output | 1 | Packet decision strobe |
| ev_count | output | EV_W | Events in the packet |
| ev_bytes | output | BY_W | Packet byte length |
| pop_samples | output | EV_W+CH_W | Samples to release from the store |

## Verification
The hardest situation to reach is a skipped cycle followed by an emitted one. Here the held-back accumulator must show up in the next count, without a second rate increment being lost or added. The bench reaches it by starving the block of samples, or by withholding the slot, for one tick right after configuration, and then supplying exactly the needed amount. A count of 6 rather than 12 at 48 kHz, or the blocking-mode jump to a full interval on the second tick, shows that the accumulator was held during the skip. A reference model that tracks the accumulator as a single total over 8000 also follows long free-running and blocking runs at several rates.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int CYCLES_PER_SEC = 8000;

  typedef enum logic {
    XM_FREE  = 1'b0,
    XM_BLOCK = 1'b1
  } xmit_mode_e;
endpackage

// File: rtl/evs_rate_split.sv
module evs_rate_split #(
  parameter int RATE_W = 18,
  parameter int DEN    = 8000,
  parameter int IW     = 8,
  localparam int NUM_W = $clog2(DEN)
) (
  input  logic [RATE_W-1:0] rate,
  output logic [IW-1:0]     whole,
  output logic [NUM_W-1:0]  frac
);
  localparam logic [RATE_W-1:0] DEN_R = RATE_W'(DEN);

  generate
    if ((DEN & (DEN - 1)) == 0) begin : g_pow2
      // power-of-two denominator: shift and mask
      assign whole = IW'(rate >> NUM_W);
      assign frac  = NUM_W'(rate & (DEN_R - RATE_W'(1)));
    end else begin : g_div
      logic [RATE_W-1:0] quo;
      logic [RATE_W-1:0] rem;
      assign quo   = rate / DEN_R;
      assign rem   = rate % DEN_R;
      assign whole = IW'(quo);
      assign frac  = NUM_W'(rem);
    end
  endgenerate
endmodule

// File: rtl/evs_accum.sv
module evs_accum #(
  parameter int DEN    = 8000,
  parameter int IW     = 8,
  localparam int NUM_W = $clog2(DEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [IW-1:0]    spc_whole,
  input  logic [NUM_W-1:0] spc_frac,
  input  logic [IW-1:0]    take,
  output logic [IW-1:0]    nxt_whole,
  output logic [NUM_W-1:0] nxt_frac
);
  localparam logic [NUM_W:0] DEN_V = (NUM_W+1)'(DEN);

  logic [IW-1:0]    rdy_whole;
  logic [NUM_W-1:0] rdy_frac;
  logic [NUM_W:0]   fsum;
  logic             wrap;

  always_comb begin
    fsum      = {1'b0, rdy_frac} + {1'b0, spc_frac};
    wrap      = (fsum >= DEN_V);
    nxt_frac  = wrap ? NUM_W'(fsum - DEN_V) : NUM_W'(fsum);
    nxt_whole = rdy_whole + spc_whole + IW'(wrap);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rdy_whole <= '0;
      rdy_frac  <= '0;
    end else if (upd) begin
      rdy_whole <= nxt_whole - take;
      rdy_frac  <= nxt_frac;
    end
  end
endmodule

// File: rtl/evs_pick.sv
module evs_pick
  import evs_pkg::*;
#(
  parameter int IW     = 8,
  parameter int EV_W   = 8,
  parameter int SYT_W  = 7,
  parameter int CH_W   = 4,
  parameter int AV_W   = 12,
  parameter int BY_W   = 16,
  localparam int NEED_W = EV_W + CH_W,
  localparam int CMP_W  = (AV_W > NEED_W) ? AV_W : NEED_W
) (
  input  xmit_mode_e         mode,
  input  logic [SYT_W-1:0]   syt,
  input  logic [CH_W-1:0]    chans,
  input  logic [IW-1:0]      nxt_whole,
  input  logic [AV_W-1:0]    avail,
  input  logic               slot_free,
  output logic [EV_W-1:0]    cnt,
  output logic [NEED_W-1:0]  need,
  output logic [BY_W-1:0]    bytes,
  output logic               go
);
  logic [IW-1:0] syt_w;

  always_comb begin
    syt_w = IW'(syt);
    if (mode == XM_BLOCK)
      cnt = (nxt_whole >= syt_w) ? EV_W'(syt) : '0;
    else
      cnt = EV_W'(nxt_whole);
    need  = NEED_W'(cnt) * NEED_W'(chans);
    bytes = (BY_W'(need) + BY_W'(2)) << 2;
    go    = slot_free && (CMP_W'(avail) >= CMP_W'(need));
  end
endmodule

// File: rtl/evsched_top.sv
module evsched_top
  import evs_pkg::*;
#(
  parameter int RATE_W = 18,
  parameter int DEN    = CYCLES_PER_SEC,
  parameter int IW     = 8,
  parameter int EV_W   = 8,
  parameter int SYT_W  = 7,
  parameter int CH_W   = 4,
  parameter int AV_W   = 12,
  parameter int BY_W   = 16,
  localparam int NUM_W  = $clog2(DEN),
  localparam int NEED_W = EV_W + CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_blocking,
  input  logic [SYT_W-1:0]  cfg_syt,
  input  logic [CH_W-1:0]   cfg_chans,
  input  logic              cycle_tick,
  input  logic [AV_W-1:0]   avail_samples,
  input  logic              slot_free,
  output logic              ev_valid,
  output logic [EV_W-1:0]   ev_count,
  output logic [BY_W-1:0]   ev_bytes,
  output logic [NEED_W-1:0] pop_samples
);
  xmit_mode_e       mode_q;
  logic [SYT_W-1:0] syt_q;
  logic [CH_W-1:0]  chans_q;
  logic [IW-1:0]    spc_whole_q;
  logic [NUM_W-1:0] spc_frac_q;

  logic [IW-1:0]     split_whole;
  logic [NUM_W-1:0]  split_frac;
  logic [IW-1:0]     nxt_whole;
  logic [NUM_W-1:0]  nxt_frac;
  logic [EV_W-1:0]   cnt;
  logic [NEED_W-1:0] need;
  logic [BY_W-1:0]   bytes;
  logic              go;
  logic              emit;

  evs_rate_split #(.RATE_W(RATE_W), .DEN(DEN), .IW(IW)) u_split (
    .rate  (cfg_rate),
    .whole (split_whole),
    .frac  (split_frac)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= XM_FREE;
      syt_q       <= '0;
      chans_q     <= '0;
      spc_whole_q <= '0;
      spc_frac_q  <= '0;
    end else if (cfg_load) begin
      mode_q      <= cfg_blocking ? XM_BLOCK : XM_FREE;
      syt_q       <= cfg_syt;
      chans_q     <= cfg_chans;
      spc_whole_q <= split_whole;
      spc_frac_q  <= split_frac;
    end
  end

  assign emit = cycle_tick && go && !cfg_load;

  evs_accum #(.DEN(DEN), .IW(IW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clr       (cfg_load),
    .upd       (emit),
    .spc_whole (spc_whole_q),
    .spc_frac  (spc_frac_q),
    .take      (IW'(cnt)),
    .nxt_whole (nxt_whole),
    .nxt_frac  (nxt_frac)
  );

  evs_pick #(
    .IW(IW), .EV_W(EV_W), .SYT_W(SYT_W), .CH_W(CH_W), .AV_W(AV_W), .BY_W(BY_W)
  ) u_pick (
    .mode      (mode_q),
    .syt       (syt_q),
    .chans     (chans_q),
    .nxt_whole (nxt_whole),
    .avail     (avail_samples),
    .slot_free (slot_free),
    .cnt       (cnt),
    .need      (need),
    .bytes     (bytes),
    .go        (go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid    <= 1'b0;
      ev_count    <= '0;
      ev_bytes    <= '0;
      pop_samples <= '0;
    end else begin
      ev_valid <= emit;
      if (emit) begin
        ev_count    <= cnt;
        ev_bytes    <= bytes;
        pop_samples <= need;
      end
    end
  end

  logic unused_frac;
  assign unused_frac = ^nxt_frac;
endmodule

// File: rtl/evsched_chk.sv
module evsched_chk #(
  parameter int IW     = 8,
  parameter int EV_W   = 8,
  parameter int SYT_W  = 7,
  parameter int CH_W   = 4,
  parameter int AV_W   = 12,
  parameter int BY_W   = 16,
  parameter int NUM_W  = 13,
  localparam int NEED_W = EV_W + CH_W,
  localparam int CMP_W  = (AV_W > NEED_W) ? AV_W : NEED_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic              cycle_tick,
  input logic              slot_free,
  input logic [AV_W-1:0]   avail_samples,
  input logic              ev_valid,
  input logic [EV_W-1:0]   ev_count,
  input logic [BY_W-1:0]   ev_bytes,
  input logic [NEED_W-1:0] pop_samples,
  input logic              blk,
  input logic [SYT_W-1:0]  syt,
  input logic [IW-1:0]     spc_whole,
  input logic [NUM_W-1:0]  spc_frac
);
  // R8
  tick_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(cycle_tick));

  // R10
  cfg_prio_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_load) |-> !ev_valid);

  // R5
  slot_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(slot_free));

  // R5
  avail_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (CMP_W'($past(avail_samples)) >= CMP_W'(pop_samples)));

  // R7
  byte_len_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_bytes == ((BY_W'(pop_samples) + BY_W'(2)) << 2)));

  // R4
  blk_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && blk) |-> (ev_count == '0 || ev_count == EV_W'(syt)));

  // R9
  free_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !blk) |-> (ev_count <= EV_W'(spc_whole) + EV_W'(spc_frac != '0)));
endmodule

bind evsched_top evsched_chk #(
  .IW(IW), .EV_W(EV_W), .SYT_W(SYT_W), .CH_W(CH_W),
  .AV_W(AV_W), .BY_W(BY_W), .NUM_W(NUM_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_load      (cfg_load),
  .cycle_tick    (cycle_tick),
  .slot_free     (slot_free),
  .avail_samples (avail_samples),
  .ev_valid      (ev_valid),
  .ev_count      (ev_count),
  .ev_bytes      (ev_bytes),
  .pop_samples   (pop_samples),
  .blk           (mode_q == evs_pkg::XM_BLOCK),
  .syt           (syt_q),
  .spc_whole     (spc_whole_q),
  .spc_frac      (spc_frac_q)
);

// File: tb/evsched_top_test.sv
module evsched_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [17:0] cfg_rate = '0;
  logic        cfg_blocking = 1'b0;
  logic [6:0]  cfg_syt = '0;
  logic [3:0]  cfg_chans = '0;
  logic        cycle_tick = 1'b0;
  logic [11:0] avail_samples = '0;
  logic        slot_free = 1'b0;
  logic        ev_valid;
  logic [7:0]  ev_count;
  logic [15:0] ev_bytes;
  logic [11:0] pop_samples;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: accumulator as a single total over 8000
  int m_ready = 0;
  int m_rate = 0;
  int m_blk = 0;
  int m_syt = 0;
  int m_ch = 0;
  int exp_cnt = 0;
  int exp_go = 0;

  // rate, blocking, interval, channels, ticks
  localparam int NVEC = 7;
  localparam int VEC [NVEC][5] = '{
    '{44100,  0, 8,  2, 40},
    '{48000,  0, 8,  2, 20},
    '{32000,  0, 8,  6, 20},
    '{88200,  0, 16, 4, 40},
    '{44100,  1, 8,  2, 40},
    '{96000,  1, 16, 2, 40},
    '{192000, 1, 32, 1, 40}
  };

  always #10 clk = ~clk;

  evsched_top uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_rate(cfg_rate),
    .cfg_blocking(cfg_blocking), .cfg_syt(cfg_syt), .cfg_chans(cfg_chans),
    .cycle_tick(cycle_tick), .avail_samples(avail_samples), .slot_free(slot_free),
    .ev_valid(ev_valid), .ev_count(ev_count), .ev_bytes(ev_bytes),
    .pop_samples(pop_samples)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int rate, input int blk, input int syt, input int ch);
    @(negedge clk);
    cfg_load = 1'b1; cfg_rate = 18'(rate); cfg_blocking = blk[0];
    cfg_syt = 7'(syt); cfg_chans = 4'(ch);
    @(negedge clk);
    cfg_load = 1'b0;
    m_ready = 0; m_rate = rate; m_blk = blk; m_syt = syt; m_ch = ch;
  endtask

  task automatic model_step(input int av, input int slot);
    int nxt;
    int fl;
    nxt = m_ready + m_rate;
    fl = nxt / 8000;
    if (m_blk != 0) exp_cnt = (fl >= m_syt) ? m_syt : 0;
    else exp_cnt = fl;
    exp_go = (slot != 0 && av >= exp_cnt * m_ch) ? 1 : 0;
    if (exp_go != 0) m_ready = nxt - exp_cnt * 8000;
  endtask

  task automatic tick(input int av, input int slot, input string tag);
    @(negedge clk);
    cycle_tick = 1'b1; avail_samples = 12'(av); slot_free = slot[0];
    model_step(av, slot);
    @(negedge clk);
    cycle_tick = 1'b0;
    chk(int'(ev_valid) == exp_go, {tag, " valid"}, int'(ev_valid), exp_go);
    if (exp_go != 0) begin
      chk(int'(ev_count) == exp_cnt, {tag, " count"}, int'(ev_count), exp_cnt);
      // R7
      chk(int'(pop_samples) == exp_cnt * m_ch, "R7 pop", int'(pop_samples), exp_cnt * m_ch);
      chk(int'(ev_bytes) == (exp_cnt * m_ch + 2) * 4, "R7 bytes", int'(ev_bytes),
          (exp_cnt * m_ch + 2) * 4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sum;
    bool_dummy: begin end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ev_valid == 1'b0, "R1 valid", int'(ev_valid), 0);
    chk(ev_count == '0, "R1 count", int'(ev_count), 0);
    chk(ev_bytes == '0, "R1 bytes", int'(ev_bytes), 0);
    chk(pop_samples == '0, "R1 pop", int'(pop_samples), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ev_valid == 1'b0, "R1 valid after release", int'(ev_valid), 0);

    // table walk: R3 free-running, R4 blocking, R6 remainder carried
    for (int v = 0; v < NVEC; v++) begin
      configure(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      for (int t = 0; t < VEC[v][4]; t++)
        tick(4000, 1, (VEC[v][1] != 0) ? "R4 R6 table" : "R3 R6 table");
    end

    // R3: 44.1 kHz over 80 packets totals 441, each 5 or 6
    configure(44100, 0, 8, 2);
    sum = 0;
    for (int t = 0; t < 80; t++) begin
      tick(4000, 1, "R3 run");
      sum += int'(ev_count);
      chk(ev_count == 8'd5 || ev_count == 8'd6, "R3 alternation", int'(ev_count), 5);
    end
    chk(sum == 441, "R3 sum", sum, 441);

    // R5: short data skips, accumulator held (6 not 12 afterwards)
    configure(48000, 0, 8, 2);
    tick(11, 1, "R5 short data");
    chk(ev_valid == 1'b0, "R5 no strobe", int'(ev_valid), 0);
    tick(12, 1, "R5 exact data");
    chk(ev_count == 8'd6, "R5 held accumulator", int'(ev_count), 6);

    // R5: slot busy skips
    tick(4000, 0, "R5 slot busy");
    tick(4000, 1, "R5 slot back");
    chk(ev_count == 8'd6, "R5 slot held accumulator", int'(ev_count), 6);

    // R8: no pulse without tick, pulse is one cycle
    @(negedge clk);
    chk(ev_valid == 1'b0, "R8 idle", int'(ev_valid), 0);

    // R4: blocking zero-event packet then full interval
    configure(44100, 1, 8, 2);
    tick(4000, 1, "R4 empty packet");
    chk(ev_count == 8'd0 && ev_bytes == 16'd8, "R4 empty bytes", int'(ev_bytes), 8);
    tick(4000, 1, "R4 full interval");
    chk(ev_count == 8'd8, "R4 interval", int'(ev_count), 8);

    // R2: reconfiguration clears accumulator (blocking build-up lost)
    tick(4000, 0, "R2 build");
    configure(44100, 1, 8, 2);
    tick(4000, 1, "R2 after clear");
    chk(ev_count == 8'd0, "R2 cleared", int'(ev_count), 0);

    // R10: load and tick together, load wins
    @(negedge clk);
    cfg_load = 1'b1; cycle_tick = 1'b1; cfg_rate = 18'd48000; cfg_blocking = 1'b0;
    cfg_syt = 7'd8; cfg_chans = 4'd2; avail_samples = 12'd4000; slot_free = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; cycle_tick = 1'b0;
    chk(ev_valid == 1'b0, "R10 no strobe", int'(ev_valid), 0);
    m_ready = 0; m_rate = 48000; m_blk = 0; m_syt = 8; m_ch = 2;
    tick(4000, 1, "R10 next tick");
    chk(ev_count == 8'd6, "R10 fresh count", int'(ev_count), 6);

    // R9: free-running 44.1 kHz never above 6
    configure(44100, 0, 8, 1);
    for (int t = 0; t < 10; t++) begin
      tick(4000, 1, "R9 ceiling");
      chk(ev_count <= 8'd6, "R9 bound", int'(ev_count), 6);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule